// File: doc/BRIEF.md
# Multi-level trap entry sequencer

This block performs the state changes a 64-bit register-windowed processor makes when it takes a trap while keeping a stack of trap levels. The core presents a trap request with a 9-bit trap type, along with its current program counters, condition codes, address-space identifier, processor-state word, window pointer, spill-room count, trap level and trap base address. On acceptance the block writes a saved-state record into a small trap-state store at the slot named by the new trap level. One cycle later it presents the next architectural values of trap level, processor state, window pointer, trap base and program counters, with a one-cycle commit strobe for the core to latch them.

When the trap level is one short of its maximum, the block still takes the trap but enters the reduced-operation (RED) condition. When the level is already at its maximum, the block takes no trap. It raises a sticky error-state output and refuses further requests until reset. A read port on the store lets the trap-return logic fetch a saved record by level.

Top module: `trap_entry_seq`

## Requirements
- R1: After a synchronous active-low reset, `trap_ready` is 1, `commit` is 0, `error_state` is 0 and every registered next-state output is 0.
- R2: A request is accepted on a rising edge where `trap_valid` and `trap_ready` are both 1. `commit` is 1 for exactly the following cycle and `trap_ready` is 0 during that cycle. With `trap_valid` low, `commit` stays 0.
- R3: When the current level is below MAXTL-1, the new level is the current level plus 1 and RED (processor-state bit 5) is not forced. When the current level equals MAXTL-1, the new level is MAXTL and bit 5 is forced to 1.
- R4: A request with current level at or above MAXTL produces no commit and writes nothing into the store. `error_state` becomes 1 on the next cycle, stays 1, and holds `trap_ready` at 0 until reset.
- R5: The store slot at index (new level masked to the store index width) receives the trap type, PC, NPC and a 64-bit state word. That word holds CCR in bits 39:32, ASI in bits 31:24, the processor state (with bit 5 as forced by R3) ANDed with 0xF3F in bits 19:8, the window pointer zero-extended in bits 7:0, and zeros elsewhere.
- R6: With GLOBAL_LEVELS=0, the new processor state is PEF (bit 4) plus PRIV (bit 2) plus exactly one globals select, plus bit 5 if forced. Trap type 0x060 selects interrupt globals (bit 11). Types 0x008, 0x030, 0x064, 0x068 and 0x06C select MMU globals (bit 10). Every other type selects alternate globals (bit 0).
- R7: Trap type 0x024 (clean window) sets the window pointer to the current pointer minus 1, modulo NWIN.
- R8: When type & 0x1C0 equals 0x080 (spill), the window pointer becomes pointer − spill-room − 2 modulo NWIN. When it equals 0x0C0 (fill), it becomes pointer + 1 modulo NWIN. Any other type leaves the pointer unchanged. All results are below NWIN.
- R9: The new trap base equals the current one with bits 14:0 cleared. Bit 14 is set to 1 when the new level is above 1, and the trap type is placed in bits 13:5.
- R10: The new PC equals the new trap base, and the new NPC equals that value plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | Trap request present |
| trap_ready | output | 1 | Sequencer can accept a request |
| trap_type | input | 9 | Trap type code |
| cur_pc | input | 64 | Current PC |
| cur_npc | input | 64 | Current next PC |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor-state word |
| cur_cwp | input | CWPW | Current window pointer |
| cur_cansave | input | CWPW | Windows free for saving |
| cur_tl | input | TLW | Current trap level |
| cur_tba | input | 64 | Current trap base register |
| commit | output | 1 | One-cycle strobe: next-state outputs are valid |
| error_state | output | 1 | Sticky: trap arrived at maximum level |
| nxt_tl | output | TLW | New trap level |
| nxt_pstate | output | 12 | New processor-state word |
| nxt_cwp | output | CWPW | New window pointer |
| nxt_tba | output | 64 | New trap base register |
| nxt_pc | output | 64 | Trap vector PC |
| nxt_npc | output | 64 | Trap vector PC plus 4 |
| rd_idx | input | TLW | Store slot to read |
| rd_tstate | output | 64 | Saved state word at slot |
| rd_tpc | output | 64 | Saved PC at slot |
| rd_tnpc | output | 64 | Saved NPC at slot |
| rd_tt | output | 9 | Saved trap type at slot |

## Verification
The bench builds the sequencer with NWIN=6 and MAXTL=5. A six-entry window ring is not a power of two, so clean-window, spill and fill traps at the edges of the ring exercise the explicit wrap logic instead of a free bit-truncation. A maximum level of 5 lets a short chain of traps walk the level from 0 up to the RED transition and then into the error state. Along the way it shows that the refused trap leaves the slot written by the previous level intact.

// File: rtl/trap_seq_pkg.sv
// Package: shared types, trap type codes and processor-state bit positions
// for the trap entry sequencer. Assumes a 12-bit processor-state word.
package trap_seq_pkg;

    localparam int PS_W = 12;

    // processor-state bit positions (the saved-state mask depends on them)
    localparam int PS_AG   = 0;
    localparam int PS_PRIV = 2;
    localparam int PS_PEF  = 4;
    localparam int PS_RED  = 5;
    localparam int PS_MG   = 10;
    localparam int PS_IG   = 11;

    localparam logic [PS_W-1:0] PS_SAVE_MASK = 12'hF3F;

    // trap type codes used for routing decisions
    localparam logic [8:0] TT_INST_FAULT  = 9'h008;
    localparam logic [8:0] TT_CLEAN_WIN   = 9'h024;
    localparam logic [8:0] TT_DATA_FAULT  = 9'h030;
    localparam logic [8:0] TT_INT_VECTOR  = 9'h060;
    localparam logic [8:0] TT_INST_MISS   = 9'h064;
    localparam logic [8:0] TT_DATA_MISS   = 9'h068;
    localparam logic [8:0] TT_DATA_PROT   = 9'h06C;
    localparam logic [8:0] TT_CLASS_MASK  = 9'h1C0;
    localparam logic [8:0] TT_SPILL_CLASS = 9'h080;
    localparam logic [8:0] TT_FILL_CLASS  = 9'h0C0;

    // one saved-state record
    typedef struct packed {
        logic [63:0] tstate;
        logic [63:0] tpc;
        logic [63:0] tnpc;
        logic [8:0]  tt;
    } trap_rec_t;

    // globals select one-hot mask chosen by trap type
    function automatic logic [PS_W-1:0] globals_for(input logic [8:0] tt);
        logic [PS_W-1:0] m;
        m = '0;
        if (tt == TT_INT_VECTOR)
            m[PS_IG] = 1'b1;
        else if (tt == TT_INST_FAULT || tt == TT_INST_MISS || tt == TT_DATA_FAULT ||
                 tt == TT_DATA_MISS || tt == TT_DATA_PROT)
            m[PS_MG] = 1'b1;
        else
            m[PS_AG] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/trap_level_ctl.sv
// Trap level control: decides the new trap level, whether RED is forced and
// whether the request must be refused. Purely combinational.
// Assumes MAXTL >= 2 and that TLW can hold MAXTL.
module trap_level_ctl #(
    parameter int MAXTL = 6,
    parameter int TLW   = $clog2(MAXTL + 1)
) (
    input  logic [TLW-1:0] cur_tl,
    output logic [TLW-1:0] new_tl,
    output logic           force_red,
    output logic           refuse
);
    localparam logic [TLW-1:0] TL_MAX  = TLW'(MAXTL);
    localparam logic [TLW-1:0] TL_EDGE = TLW'(MAXTL - 1);

    // level step and saturation into RED
    always_comb begin
        refuse    = (cur_tl >= TL_MAX);
        force_red = 1'b0;
        new_tl    = cur_tl;
        if (!refuse) begin
            new_tl = cur_tl + 1'b1;
            if (cur_tl >= TL_EDGE) force_red = 1'b1;
        end
    end

    // R3: a non-refused level never exceeds the maximum
    always_comb begin
        if (!refuse) p_level_bound_r3: assert (new_tl <= TL_MAX);
    end
endmodule

// File: rtl/trap_window_ctl.sv
// Window pointer control: computes the window pointer after trap entry for
// clean-window, spill and fill traps, wrapping modulo NWIN (any NWIN >= 2).
// Assumes cur_cwp and cur_cansave are both below NWIN.
module trap_window_ctl
    import trap_seq_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CWPW = $clog2(NWIN)
) (
    input  logic [8:0]      tt,
    input  logic [CWPW-1:0] cur_cwp,
    input  logic [CWPW-1:0] cur_cansave,
    output logic [CWPW-1:0] new_cwp
);
    localparam int SW = CWPW + 3;
    localparam logic [SW-1:0]   N_EXT  = SW'(NWIN);
    localparam logic [CWPW-1:0] N_TOP  = CWPW'(NWIN - 1);

    logic [SW-1:0]   spill_raw;
    logic [SW-1:0]   spill_red1;
    logic [SW-1:0]   spill_red2;
    logic [CWPW-1:0] dec_one;
    logic [CWPW-1:0] inc_one;

    // spill target: cwp + 2N - cansave - 2 lies in [N-1, 3N-3]; two reductions
    always_comb begin
        spill_raw  = SW'(cur_cwp) + (N_EXT << 1) - SW'(cur_cansave) - SW'(2);
        spill_red1 = (spill_raw  >= N_EXT) ? spill_raw  - N_EXT : spill_raw;
        spill_red2 = (spill_red1 >= N_EXT) ? spill_red1 - N_EXT : spill_red1;
    end

    // single-step neighbours with explicit wrap
    always_comb begin
        dec_one = (cur_cwp == '0)    ? N_TOP : cur_cwp - 1'b1;
        inc_one = (cur_cwp == N_TOP) ? '0    : cur_cwp + 1'b1;
    end

    // choose by trap type / class
    always_comb begin
        if (tt == TT_CLEAN_WIN)
            new_cwp = dec_one;
        else if ((tt & TT_CLASS_MASK) == TT_SPILL_CLASS)
            new_cwp = spill_red2[CWPW-1:0];
        else if ((tt & TT_CLASS_MASK) == TT_FILL_CLASS)
            new_cwp = inc_one;
        else
            new_cwp = cur_cwp;
    end

    // R8: every result stays inside the window ring
    always_comb begin
        p_cwp_ring_r8: assert (new_cwp <= N_TOP);
    end
endmodule

// File: rtl/trap_state_store.sv
// Trap state store: one saved-state record per trap level, written on trap
// entry and read combinationally by index. Cleared by synchronous reset.
module trap_state_store
    import trap_seq_pkg::*;
#(
    parameter int TLW   = 3,
    parameter int DEPTH = 1 << TLW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [TLW-1:0]  wr_idx,
    input  trap_rec_t       wr_rec,
    input  logic [TLW-1:0]  rd_idx,
    output trap_rec_t       rd_rec
);
    trap_rec_t slots [DEPTH];

    // per-slot storage built by generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // write slot g on a matching entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (wr_en && wr_idx == TLW'(g))
                slots[g] <= wr_rec;
        end
    end

    // combinational read
    assign rd_rec = slots[rd_idx];

    // R5: the written slot holds the record on the next cycle
    p_store_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slots[$past(wr_idx)] == $past(wr_rec));
endmodule

// File: rtl/trap_entry_seq.sv
// Trap entry sequencer top: accepts a trap request in one cycle, pushes the
// saved-state record, and one cycle later presents the next architectural
// state with a commit strobe. A trap at maximum level sets a sticky error.
// Assumes the core holds its request inputs stable while trap_valid is high.
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int NWIN          = 8,
    parameter int MAXTL         = 6,
    parameter bit GLOBAL_LEVELS = 1'b0,
    parameter int CWPW          = $clog2(NWIN),
    parameter int TLW           = $clog2(MAXTL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid,
    output logic            trap_ready,
    input  logic [8:0]      trap_type,
    input  logic [63:0]     cur_pc,
    input  logic [63:0]     cur_npc,
    input  logic [7:0]      cur_ccr,
    input  logic [7:0]      cur_asi,
    input  logic [11:0]     cur_pstate,
    input  logic [CWPW-1:0] cur_cwp,
    input  logic [CWPW-1:0] cur_cansave,
    input  logic [TLW-1:0]  cur_tl,
    input  logic [63:0]     cur_tba,
    output logic            commit,
    output logic            error_state,
    output logic [TLW-1:0]  nxt_tl,
    output logic [11:0]     nxt_pstate,
    output logic [CWPW-1:0] nxt_cwp,
    output logic [63:0]     nxt_tba,
    output logic [63:0]     nxt_pc,
    output logic [63:0]     nxt_npc,
    input  logic [TLW-1:0]  rd_idx,
    output logic [63:0]     rd_tstate,
    output logic [63:0]     rd_tpc,
    output logic [63:0]     rd_tnpc,
    output logic [8:0]      rd_tt
);
    localparam int DEPTH = 1 << TLW;

    logic            accept;
    logic            do_entry;
    logic [TLW-1:0]  lvl_new;
    logic            lvl_red;
    logic            lvl_refuse;
    logic [CWPW-1:0] win_new;
    logic [11:0]     ps_base;
    logic [11:0]     ps_new;
    logic [63:0]     tba_new;
    trap_rec_t       rec_new;
    trap_rec_t       rec_rd;
    logic            commit_q;
    logic            err_q;

    trap_level_ctl #(.MAXTL(MAXTL), .TLW(TLW)) u_level (
        .cur_tl    (cur_tl),
        .new_tl    (lvl_new),
        .force_red (lvl_red),
        .refuse    (lvl_refuse)
    );

    trap_window_ctl #(.NWIN(NWIN), .CWPW(CWPW)) u_window (
        .tt          (trap_type),
        .cur_cwp     (cur_cwp),
        .cur_cansave (cur_cansave),
        .new_cwp     (win_new)
    );

    // handshake: one request per two cycles, none after an error
    assign trap_ready = !commit_q && !err_q;
    assign accept     = trap_valid && trap_ready;
    assign do_entry   = accept && !lvl_refuse;

    // state word as it stands when saved (RED already applied)
    always_comb begin
        ps_base = cur_pstate;
        if (lvl_red) ps_base[PS_RED] = 1'b1;
    end

    // next processor state: globals routing unless a level feature exists
    generate
        if (GLOBAL_LEVELS) begin : g_keep_ps
            assign ps_new = ps_base;
        end else begin : g_route_ps
            always_comb begin
                ps_new = globals_for(trap_type);
                ps_new[PS_PEF]  = 1'b1;
                ps_new[PS_PRIV] = 1'b1;
                ps_new[PS_RED]  = lvl_red;
            end
        end
    endgenerate

    // vector base: low field replaced by level flag and trap type
    always_comb begin
        tba_new        = cur_tba;
        tba_new[14:0]  = {(lvl_new > TLW'(1)), trap_type, 5'b0};
    end

    // saved-state record packing
    always_comb begin
        rec_new.tstate = {24'b0, cur_ccr, cur_asi, 4'b0, ps_base & PS_SAVE_MASK,
                          8'(cur_cwp)};
        rec_new.tpc    = cur_pc;
        rec_new.tnpc   = cur_npc;
        rec_new.tt     = trap_type;
    end

    trap_state_store #(.TLW(TLW), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (do_entry),
        .wr_idx (lvl_new & TLW'(DEPTH - 1)),
        .wr_rec (rec_new),
        .rd_idx (rd_idx),
        .rd_rec (rec_rd)
    );

    assign rd_tstate = rec_rd.tstate;
    assign rd_tpc    = rec_rd.tpc;
    assign rd_tnpc   = rec_rd.tnpc;
    assign rd_tt     = rec_rd.tt;

    // commit strobe and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            commit_q <= do_entry;
            if (accept && lvl_refuse) err_q <= 1'b1;
        end
    end

    // next-state output registers, loaded on trap entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_tl     <= '0;
            nxt_pstate <= '0;
            nxt_cwp    <= '0;
            nxt_tba    <= '0;
            nxt_pc     <= '0;
            nxt_npc    <= '0;
        end else if (do_entry) begin
            nxt_tl     <= lvl_new;
            nxt_pstate <= ps_new;
            nxt_cwp    <= win_new;
            nxt_tba    <= tba_new;
            nxt_pc     <= tba_new;
            nxt_npc    <= tba_new + 64'd4;
        end
    end

    assign commit      = commit_q;
    assign error_state = err_q;

    // R2: commit lasts one cycle and blocks acceptance while high
    p_commit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !trap_ready);
    // R3: committed level is one above the level seen at acceptance
    p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_entry |=> nxt_tl == $past(cur_tl) + 1'b1);
    // R4: error is sticky and never accompanied by a commit
    p_error_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        error_state |=> error_state && !commit);
    // R6: exactly one globals select after a routed entry
    p_one_globals_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !GLOBAL_LEVELS) |->
            $onehot({nxt_pstate[PS_IG], nxt_pstate[PS_MG], nxt_pstate[PS_AG]}));
    // R10: NPC follows PC by one instruction
    p_npc_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> nxt_npc == nxt_pc + 64'd4);
endmodule

// File: tb/trap_entry_seq_test.sv
`timescale 1ns/1ps
module trap_entry_seq_test;
    localparam int NWIN  = 6;
    localparam int MAXTL = 5;
    localparam int CWPW  = 3;
    localparam int TLW   = 3;

    localparam logic [63:0] PC0  = 64'h0000_0040_0000_1000;
    localparam logic [63:0] TBA0 = 64'hFFFF_0000_1234_5678;
    localparam logic [7:0]  CCR0 = 8'hA5;
    localparam logic [7:0]  ASI0 = 8'h80;
    localparam logic [11:0] PS0  = 12'h0C2;

    typedef struct packed {
        logic [8:0]  tt;
        logic [2:0]  tl;
        logic [2:0]  cwp;
        logic [2:0]  cs;
        logic [2:0]  etl;
        logic [2:0]  ecwp;
        logic [11:0] eps;
    } vec_t;

    // stimulus and expected next state
    localparam vec_t VEC [8] = '{
        '{9'h024, 3'd0, 3'd0, 3'd0, 3'd1, 3'd5, 12'h015},  // R7 clean wrap
        '{9'h080, 3'd1, 3'd1, 3'd3, 3'd2, 3'd2, 12'h015},  // R8 spill wrap
        '{9'h0C5, 3'd2, 3'd5, 3'd0, 3'd3, 3'd0, 12'h015},  // R8 fill wrap
        '{9'h060, 3'd0, 3'd3, 3'd1, 3'd1, 3'd3, 12'h814},  // R6 interrupt globals
        '{9'h068, 3'd3, 3'd4, 3'd2, 3'd4, 3'd4, 12'h414},  // R6 MMU globals
        '{9'h030, 3'd4, 3'd2, 3'd1, 3'd5, 3'd2, 12'h434},  // R3 RED at MAXTL-1
        '{9'h0BC, 3'd0, 3'd0, 3'd5, 3'd1, 3'd5, 12'h015},  // R8 spill, large cansave
        '{9'h105, 3'd2, 3'd2, 3'd4, 3'd3, 3'd2, 12'h015}   // R8 other class unchanged
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_valid = 1'b0;
    logic            trap_ready;
    logic [8:0]      trap_type = '0;
    logic [63:0]     cur_pc = '0;
    logic [63:0]     cur_npc = '0;
    logic [7:0]      cur_ccr = '0;
    logic [7:0]      cur_asi = '0;
    logic [11:0]     cur_pstate = '0;
    logic [CWPW-1:0] cur_cwp = '0;
    logic [CWPW-1:0] cur_cansave = '0;
    logic [TLW-1:0]  cur_tl = '0;
    logic [63:0]     cur_tba = '0;
    logic            commit;
    logic            error_state;
    logic [TLW-1:0]  nxt_tl;
    logic [11:0]     nxt_pstate;
    logic [CWPW-1:0] nxt_cwp;
    logic [63:0]     nxt_tba;
    logic [63:0]     nxt_pc;
    logic [63:0]     nxt_npc;
    logic [TLW-1:0]  rd_idx = '0;
    logic [63:0]     rd_tstate;
    logic [63:0]     rd_tpc;
    logic [63:0]     rd_tnpc;
    logic [8:0]      rd_tt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trap_entry_seq #(.NWIN(NWIN), .MAXTL(MAXTL), .GLOBAL_LEVELS(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
        .trap_type(trap_type), .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr),
        .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_cwp(cur_cwp),
        .cur_cansave(cur_cansave), .cur_tl(cur_tl), .cur_tba(cur_tba),
        .commit(commit), .error_state(error_state), .nxt_tl(nxt_tl),
        .nxt_pstate(nxt_pstate), .nxt_cwp(nxt_cwp), .nxt_tba(nxt_tba),
        .nxt_pc(nxt_pc), .nxt_npc(nxt_npc), .rd_idx(rd_idx), .rd_tstate(rd_tstate),
        .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc), .rd_tt(rd_tt)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // present one request at a falling edge
    task automatic drive(input logic [8:0] tt, input logic [2:0] tl,
                         input logic [2:0] cwp, input logic [2:0] cs, input int k);
        trap_type   = tt;
        cur_tl      = tl;
        cur_cwp     = cwp;
        cur_cansave = cs;
        cur_pc      = PC0 + 64'(k * 16);
        cur_npc     = PC0 + 64'(k * 16 + 4);
        cur_ccr     = CCR0;
        cur_asi     = ASI0;
        cur_pstate  = PS0;
        cur_tba     = TBA0;
        trap_valid  = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] exp_tba;
        logic [11:0] ps_saved;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 ready", 64'(trap_ready), 64'd1);
        check("R1 commit", 64'(commit), 64'd0);
        check("R1 error", 64'(error_state), 64'd0);
        check("R1 pc", nxt_pc, 64'd0);
        // R2 no request, no commit
        repeat (3) @(negedge clk);
        check("R2 idle commit", 64'(commit), 64'd0);

        for (int i = 0; i < 8; i++) begin
            drive(VEC[i].tt, VEC[i].tl, VEC[i].cwp, VEC[i].cs, i);
            check("R2 ready before", 64'(trap_ready), 64'd1);
            @(negedge clk);
            trap_valid = 1'b0;
            exp_tba = {TBA0[63:15], (VEC[i].etl > 3'd1), VEC[i].tt, 5'b0};
            check("R2 commit", 64'(commit), 64'd1);
            check("R2 ready low", 64'(trap_ready), 64'd0);
            check("R3 level", 64'(nxt_tl), 64'(VEC[i].etl));
            check("R6 pstate", 64'(nxt_pstate), 64'(VEC[i].eps));
            check("R7/R8 cwp", 64'(nxt_cwp), 64'(VEC[i].ecwp));
            check("R9 tba", nxt_tba, exp_tba);
            check("R10 pc", nxt_pc, exp_tba);
            check("R10 npc", nxt_npc, exp_tba + 64'd4);
            ps_saved = (PS0 | {6'b0, VEC[i].eps[5], 5'b0}) & 12'hF3F;
            rd_idx = VEC[i].etl;
            #1;
            check("R5 tstate", rd_tstate, {24'b0, CCR0, ASI0, 4'b0, ps_saved, 5'b0, VEC[i].cwp});
            check("R5 tpc", rd_tpc, PC0 + 64'(i * 16));
            check("R5 tnpc", rd_tnpc, PC0 + 64'(i * 16 + 4));
            check("R5 tt", 64'(rd_tt), 64'(VEC[i].tt));
            @(negedge clk);
            check("R2 single commit", 64'(commit), 64'd0);
            check("R2 ready again", 64'(trap_ready), 64'd1);
        end

        // R4 trap at the maximum level is refused
        drive(9'h041, 3'd5, 3'd1, 3'd0, 9);
        @(negedge clk);
        trap_valid = 1'b0;
        check("R4 no commit", 64'(commit), 64'd0);
        check("R4 error set", 64'(error_state), 64'd1);
        check("R4 ready held", 64'(trap_ready), 64'd0);
        check("R4 outputs kept", 64'(nxt_tl), 64'd3);
        rd_idx = 3'd5;
        #1;
        check("R4 slot untouched", 64'(rd_tt), 64'h030);
        // R4 further requests ignored while in error
        drive(9'h024, 3'd0, 3'd2, 3'd0, 10);
        @(negedge clk);
        @(negedge clk);
        trap_valid = 1'b0;
        check("R4 sticky", 64'(error_state), 64'd1);
        check("R4 still no commit", 64'(commit), 64'd0);
        rd_idx = 3'd1;
        #1;
        check("R4 slot1 untouched", 64'(rd_tt), 64'h0BC);

        // R1 reset clears the error
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 error cleared", 64'(error_state), 64'd0);
        check("R1 ready restored", 64'(trap_ready), 64'd1);
        check("R1 tl cleared", 64'(nxt_tl), 64'd0);
        finish_run();
    end
endmodule